// File: doc/BRIEF.md
# Sticky Lock and Start-Up Sequencer

This block decides when a clock buffer's outputs may be turned on after power-up or after leaving power-down. A free-running local timebase clock drives all of its logic. It watches a reference clock input, treated as a plain asynchronous data signal, and counts its rising edges through a synchronizer over fixed windows of the timebase. It also takes a PLL lock indication, a power-good input and an active-low power-down input.

When power is good and power-down is released, the sequencer waits for reference activity and then for the PLL lock indication to stay high for a qualification period. It then raises a lock status output and, in the same cycle, a global output enable. From then on the lock output is sticky. It ignores later loss of PLL lock or of the reference clock, and it clears only when power-good falls or power-down is asserted. The internal states are off, waiting for the clock, waiting for lock, and locked.

The parameters must keep the worst start-up latency far inside a 1 ms budget. That budget is 250,000 timebase cycles at 250 MHz, and the default parameters give a latency of a few dozen cycles.

Top module: `lockseq_top`

## Requirements
- R1: While rst_n is low, lock and out_en are 0 whatever the other inputs are.
- R2: lock rises only if, in the cycle before, pwr_good and pwrdn_n were both 1, reference activity was detected and the PLL lock had been qualified. If any one of these conditions is missing, lock stays 0.
- R3: Reference activity means at least MIN_EDGES synchronized rising edges of ref_clk in every window of WIN_CYCLES timebase cycles. With no reference clock, or with too few edges (for example a period of 12 timebase cycles against the defaults of 3 edges in 16 cycles), lock stays 0.
- R4: out_en equals lock in every cycle, so the outputs are enabled only while lock is 1.
- R5: Once lock is 1, it stays 1 while pwr_good and pwrdn_n stay 1, even if pll_lock falls or ref_clk stops.
- R6: In the cycle after pwr_good or pwrdn_n is sampled 0, lock and out_en are both 0.
- R7: pll_lock must be high for QUAL_CYCLES consecutive timebase cycles before it counts as stable. Pulses shorter than that never raise lock.
- R8: With pwr_good and pwrdn_n high, a running reference and pll_lock held high, lock rises at least QUAL_CYCLES and at most SYNC_STAGES + 2*WIN_CYCLES + QUAL_CYCLES + 8 cycles after power-down is released. This bound is far inside the 1 ms budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock, sampled as asynchronous data |
| pll_lock | input | 1 | Raw PLL lock indication |
| pwr_good | input | 1 | Power valid, high when good |
| pwrdn_n | input | 1 | Power-down request, active low |
| lock | output | 1 | Sticky lock status |
| out_en | output | 1 | Global clock output enable |

## Verification
The checker watches the following on every cycle: out_en matches lock, lock stays high while power is good and power-down is released, and lock clears in the cycle after a forced-off condition. It also checks that every rise of lock follows a qualified PLL run and detected activity, and that the wait with all conditions met never exceeds the qualification period plus a small margin. Only the bench scenarios can show the effect of the reference itself: that a missing or too-slow clock keeps lock low, that short lock pulses are rejected, and that the latency measured from power-down release lands inside the stated window.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;

  typedef enum logic [1:0] {
    ST_OFF       = 2'd0,
    ST_WAIT_CLK  = 2'd1,
    ST_WAIT_LOCK = 2'd2,
    ST_LOCKED    = 2'd3
  } seq_state_e;

  // bits needed to hold values 0..maxval
  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 1) ? 1 : $clog2(maxval + 1);
  endfunction

  // worst cycles from release to lock: activity needs a partial plus a full
  // window behind the synchronizer; qualification runs in parallel
  function automatic int unsigned worst_start_cycles(input int unsigned sync_stages,
                                                     input int unsigned win_cycles,
                                                     input int unsigned qual_cycles);
    int unsigned act;
    act = sync_stages + 1 + 2 * win_cycles;
    return ((act > qual_cycles) ? act : qual_cycles) + 3;
  endfunction

endpackage

// File: rtl/lockseq_sync.sv
module lockseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= 1'b0;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lockseq_activity.sv
module lockseq_activity
  import lockseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WIN_CYCLES  = 16,
  parameter int unsigned MIN_EDGES   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ref_in,
  output logic ref_edge,
  output logic active
);
  localparam int unsigned WW = cnt_width(WIN_CYCLES - 1);
  localparam int unsigned EW = cnt_width(MIN_EDGES);

  logic          ref_s;
  logic          ref_prev;
  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt;
  logic [EW-1:0] edge_nxt;
  logic          win_end;

  lockseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ref_in),
    .q    (ref_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_prev <= 1'b0;
    else        ref_prev <= ref_s;
  end

  assign ref_edge = ref_s & ~ref_prev;
  assign win_end  = (win_cnt == WW'(WIN_CYCLES - 1));

  // saturating edge count for the current window
  always_comb begin
    edge_nxt = edge_cnt;
    if (ref_edge && (edge_cnt != EW'(MIN_EDGES)))
      edge_nxt = edge_cnt + EW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      active   <= 1'b0;
    end else if (clr) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      active   <= 1'b0;
    end else begin
      win_cnt <= win_end ? '0 : win_cnt + WW'(1);
      if (win_end) begin
        active   <= (edge_nxt >= EW'(MIN_EDGES));
        edge_cnt <= '0;
      end else begin
        edge_cnt <= edge_nxt;
      end
    end
  end
endmodule

// File: rtl/lockseq_qual.sv
module lockseq_qual
  import lockseq_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pll_lock,
  output logic stable
);
  localparam int unsigned QW = cnt_width(QUAL_CYCLES);

  logic [QW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           run_cnt <= '0;
    else if (clr || !pll_lock)            run_cnt <= '0;
    else if (run_cnt != QW'(QUAL_CYCLES)) run_cnt <= run_cnt + QW'(1);
  end

  assign stable = (run_cnt == QW'(QUAL_CYCLES));
endmodule

// File: rtl/lockseq_top.sv
module lockseq_top
  import lockseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WIN_CYCLES  = 16,
  parameter int unsigned MIN_EDGES   = 3,
  parameter int unsigned QUAL_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk,
  input  logic pll_lock,
  input  logic pwr_good,
  input  logic pwrdn_n,
  output logic lock,
  output logic out_en
);
  localparam int unsigned START_BOUND =
    worst_start_cycles(SYNC_STAGES, WIN_CYCLES, QUAL_CYCLES);

  seq_state_e state, state_nxt;
  logic force_off;
  logic clk_active;
  logic ref_edge;
  logic lock_stable;
  logic lock_grant;
  logic lock_q;
  logic out_en_q;

  assign force_off = ~pwr_good | ~pwrdn_n;

  lockseq_activity #(
    .SYNC_STAGES(SYNC_STAGES),
    .WIN_CYCLES (WIN_CYCLES),
    .MIN_EDGES  (MIN_EDGES)
  ) u_act (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (force_off),
    .ref_in  (ref_clk),
    .ref_edge(ref_edge),
    .active  (clk_active)
  );

  lockseq_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (force_off),
    .pll_lock(pll_lock),
    .stable  (lock_stable)
  );

  assign lock_grant = (state == ST_WAIT_LOCK) & clk_active & lock_stable & ~force_off;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_OFF:       state_nxt = ST_WAIT_CLK;
      ST_WAIT_CLK:  if (clk_active) state_nxt = ST_WAIT_LOCK;
      ST_WAIT_LOCK: begin
        if (!clk_active)      state_nxt = ST_WAIT_CLK;
        else if (lock_stable) state_nxt = ST_LOCKED;
      end
      ST_LOCKED:    state_nxt = ST_LOCKED;
      default:      state_nxt = ST_OFF;
    endcase
    if (force_off) state_nxt = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      lock_q   <= 1'b0;
      out_en_q <= 1'b0;
    end else begin
      state    <= state_nxt;
      out_en_q <= (state_nxt == ST_LOCKED);
      if (force_off)       lock_q <= 1'b0;
      else if (lock_grant) lock_q <= 1'b1;
    end
  end

  assign lock   = lock_q;
  assign out_en = out_en_q;

  logic unused_ok;
  assign unused_ok = ref_edge & (START_BOUND != 0);
endmodule

// File: rtl/lockseq_chk.sv
module lockseq_chk
  import lockseq_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 32
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic pwrdn_n,
  input logic pll_lock,
  input logic lock,
  input logic out_en,
  input logic clk_active,
  input logic force_off
);
  localparam int unsigned RW = cnt_width(QUAL_CYCLES);
  localparam int unsigned WAITW = cnt_width(QUAL_CYCLES + 4);

  logic [RW-1:0]    pll_run;
  logic [WAITW-1:0] wait_cnt;

  // consecutive cycles with pll_lock high, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           pll_run <= '0;
    else if (!pll_lock)                   pll_run <= '0;
    else if (pll_run != RW'(QUAL_CYCLES)) pll_run <= pll_run + RW'(1);
  end

  // cycles spent unlocked while every start condition holds
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else if (force_off || !clk_active || !pll_lock || lock) wait_cnt <= '0;
    else if (wait_cnt != WAITW'(QUAL_CYCLES + 4)) wait_cnt <= wait_cnt + WAITW'(1);
  end

  a_r2_all_conditions: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(pwr_good && pwrdn_n && clk_active));

  a_r4_enable_tracks_lock: assert property (@(posedge clk) disable iff (!rst_n)
    lock == out_en);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && pwr_good && pwrdn_n) |=> lock);

  a_r6_forced_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good || !pwrdn_n) |=> (!lock && !out_en));

  a_r7_qualified_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> ($past(pll_run) >= RW'(QUAL_CYCLES)));

  a_r8_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= WAITW'(QUAL_CYCLES + 3));
endmodule

bind lockseq_top lockseq_chk #(.QUAL_CYCLES(QUAL_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_good  (pwr_good),
  .pwrdn_n   (pwrdn_n),
  .pll_lock  (pll_lock),
  .lock      (lock),
  .out_en    (out_en),
  .clk_active(clk_active),
  .force_off (force_off)
);

// File: tb/lockseq_top_tb.sv
`timescale 1ns/1ps
module lockseq_top_tb;
  localparam int SYNC_STAGES = 2;
  localparam int WIN_CYCLES  = 16;
  localparam int MIN_EDGES   = 3;
  localparam int QUAL_CYCLES = 32;
  localparam int LAT_MAX     = SYNC_STAGES + 2 * WIN_CYCLES + QUAL_CYCLES + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic pll_lock = 1'b0;
  logic pwr_good = 1'b0;
  logic pwrdn_n = 1'b0;
  logic lock, out_en;
  logic [1:0] ref_mode = 2'd0; // 0 none, 1 fast (period 4), 2 slow (period 12)
  int ref_cnt = 0;
  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  lockseq_top #(
    .SYNC_STAGES(SYNC_STAGES), .WIN_CYCLES(WIN_CYCLES),
    .MIN_EDGES(MIN_EDGES), .QUAL_CYCLES(QUAL_CYCLES)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .pll_lock(pll_lock),
    .pwr_good(pwr_good), .pwrdn_n(pwrdn_n), .lock(lock), .out_en(out_en)
  );

  always @(negedge clk) begin
    if (ref_mode == 2'd0) begin
      ref_clk <= 1'b0;
      ref_cnt <= 0;
    end else begin
      if (ref_cnt + 1 >= ((ref_mode == 2'd1) ? 2 : 6)) begin
        ref_cnt <= 0;
        ref_clk <= ~ref_clk;
      end else begin
        ref_cnt <= ref_cnt + 1;
      end
    end
  end

  // row: pg, pdn, mode[1:0], pll, wait[15:0], expected lock, req[3:0]
  localparam int NV = 11;
  localparam logic [25:0] VECS [NV] = '{
    {1'b1, 1'b1, 2'd0, 1'b1, 16'd200, 1'b0, 4'd3}, // R3 no reference clock
    {1'b1, 1'b1, 2'd2, 1'b1, 16'd200, 1'b0, 4'd3}, // R3 too few edges
    {1'b1, 1'b1, 2'd1, 1'b0, 16'd200, 1'b0, 4'd2}, // R2 no PLL lock
    {1'b0, 1'b1, 2'd1, 1'b1, 16'd200, 1'b0, 4'd2}, // R2 no power
    {1'b1, 1'b0, 2'd1, 1'b1, 16'd200, 1'b0, 4'd2}, // R2 power-down held
    {1'b1, 1'b1, 2'd1, 1'b1, 16'd200, 1'b1, 4'd2}, // R2 all conditions met
    {1'b1, 1'b1, 2'd1, 1'b0, 16'd100, 1'b1, 4'd5}, // R5 PLL lock lost
    {1'b1, 1'b1, 2'd0, 1'b0, 16'd100, 1'b1, 4'd5}, // R5 reference lost too
    {1'b1, 1'b0, 2'd1, 1'b1, 16'd5,   1'b0, 4'd6}, // R6 power-down clears
    {1'b1, 1'b1, 2'd1, 1'b1, 16'd200, 1'b1, 4'd2}, // R2 relock
    {1'b0, 1'b1, 2'd1, 1'b1, 16'd5,   1'b0, 4'd6}  // R6 power loss clears
  };

  task automatic check(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic drive(input logic pg, input logic pdn, input logic [1:0] m, input logic pl);
    @(negedge clk);
    pwr_good = pg; pwrdn_n = pdn; ref_mode = m; pll_lock = pl;
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int n;
    logic seen;
    // R1: favourable inputs during reset
    pwr_good = 1'b1; pwrdn_n = 1'b1; ref_mode = 2'd1; pll_lock = 1'b1;
    repeat (120) @(posedge clk);
    #1;
    check("R1 lock in reset", lock, 1'b0);
    check("R1 out_en in reset", out_en, 1'b0);
    drive(1'b1, 1'b0, 2'd0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VECS[i];
      drive(v[25], v[24], v[23:22], v[21]);
      repeat (int'(v[20:5])) @(posedge clk);
      #1;
      check($sformatf("R%0d row %0d lock", v[3:0], i), lock, v[4]);
      check($sformatf("R4 row %0d out_en", i), out_en, v[4]); // R4
    end

    // R6: clear one cycle after power-down sampled low
    drive(1'b1, 1'b1, 2'd1, 1'b1);
    repeat (200) @(posedge clk);
    #1;
    check("R6 locked before drop", lock, 1'b1);
    drive(1'b1, 1'b0, 2'd1, 1'b1);
    @(posedge clk); #1;
    check("R6 lock one cycle after", lock, 1'b0);
    check("R6 out_en one cycle after", out_en, 1'b0);

    // R7: pll pulses shorter than qualification never lock
    drive(1'b1, 1'b1, 2'd1, 1'b0);
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, 1'b1, 2'd1, 1'b1);
      for (int c = 0; c < QUAL_CYCLES - 4; c++) begin
        @(posedge clk); #1;
        if (lock) seen = 1'b1;
      end
      drive(1'b1, 1'b1, 2'd1, 1'b0);
      repeat (2) @(posedge clk);
      #1;
      if (lock) seen = 1'b1;
    end
    check("R7 short pulses rejected", seen, 1'b0);
    drive(1'b1, 1'b1, 2'd1, 1'b1);
    repeat (QUAL_CYCLES + 10) @(posedge clk);
    #1;
    check("R7 held lock accepted", lock, 1'b1);

    // R8: latency from power-down release
    drive(1'b1, 1'b0, 2'd1, 1'b1);
    repeat (3) @(posedge clk);
    drive(1'b1, 1'b1, 2'd1, 1'b1);
    n = 0;
    while (!lock && n < 1000) begin
      @(posedge clk); #1;
      n++;
    end
    check("R8 latency not below qualification", (n >= QUAL_CYCLES), 1'b1);
    check("R8 latency within bound", (n <= LAT_MAX), 1'b1);
    if (n > LAT_MAX) $display("FAIL R8 detail: actual %0d expected <= %0d", n, LAT_MAX);

    // R3/R5: stopping the reference after lock keeps lock
    drive(1'b1, 1'b1, 2'd0, 1'b1);
    repeat (100) @(posedge clk);
    #1;
    check("R5 reference stop after lock", lock, 1'b1);

    finish_run();
  end
endmodule